// File: doc/BRIEF.md
# Interrupt Shadow Inhibit Tracker

This block remembers the one-instruction window during which a processor core must hold off interrupts, debug traps or both. That window follows an instruction that sets the interrupt-enable flag or loads the stack segment. The core arms the tracker with a small mask when such an instruction retires. The tracker records the mask together with the retired-instruction count at which the window closes, which is the arm-time count plus one. Any number of query ports can then ask whether a given set of inhibit kinds is still in force.

The retired-instruction count comes from outside the block. It is compared against the stored end count by wrap-safe subtraction, so the window stays correct when the counter rolls over. A stack-segment-load shadow cannot be chained: while one is live, further arm requests are dropped. A clear strobe, issued when the core wakes from halt, wipes the stored mask. Query results are combinational from the stored state, so a query in the same cycle as an arm still sees the old contents.

Top module: `irq_shadow_tracker`

## Requirements
- R1: An accepted arm (`arm` high, not blocked, `clr` low) at count N stores the arm mask and an end count of N+1. Both take effect from the next clock cycle.
- R2: Mask bits are bit0 interrupts, bit1 debug traps and bit2 stack-segment load. An arm whose mask has bit2 set stores all three bits.
- R3: An arm request is ignored when the stored mask has bit2 set and the current count is within the window. The stored mask and end count then stay unchanged, so the window is not extended.
- R4: A query reports inhibited only when the current count is within the window and every bit of its nonzero query mask is present in the stored mask. The result is combinational, and an arm in the same cycle is not yet visible to it.
- R5: The window test is the count being at most the end count, evaluated as a signed difference. A window armed at count 2^32-1 therefore covers counts 2^32-1 and 0 and ends at 1.
- R6: `clr` zeroes the stored mask from the next cycle. When `clr` and `arm` are high together, the clear wins and the arm is dropped.
- R7: Synchronous reset zeroes the stored mask and end count, so every query reports not inhibited.
- R8: Once the count passes the end count, the same query that was inhibited reports not inhibited.
- R9: Each query port is evaluated independently against the same stored state.
- R10: A query mask of zero always reports not inhibited.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| icount | input | CNT_W | Current retired-instruction count |
| arm | input | 1 | Arm strobe for a new shadow |
| arm_mask | input | 3 | Inhibit kinds to arm (bit0 intr, bit1 debug, bit2 stack load) |
| clr | input | 1 | Clear strobe, zeroes stored mask |
| q_mask | input | NQ*3 | Query masks, port i in bits [3i+2:3i] |
| q_hit | output | NQ | Per-port inhibited result |

## Verification
A query result is due in the same cycle as its inputs. The bench therefore sets the count and query mask a moment after the falling edge and reads `q_hit` shortly afterwards, before the next rising edge. Arm, clear and reset act on the rising edge. Their effect is read after the following falling edge, which is exactly one register stage later. The same-cycle case reads the query before that edge to show the old contents, then again after it to show the new ones.

// File: rtl/shadow_pkg.sv
package shadow_pkg;

    localparam int MASK_W  = 3;
    localparam int BIT_INT = 0;
    localparam int BIT_DBG = 1;
    localparam int BIT_SS  = 2;

    typedef logic [MASK_W-1:0] inh_mask_t;

    // A stack-segment load inhibits everything for the next instruction.
    function automatic inh_mask_t widen_arm(input inh_mask_t m);
        inh_mask_t r;
        r = m;
        if (m[BIT_SS]) begin
            r = '1;
        end
        return r;
    endfunction

    // Nonzero query whose bits are all held.
    function automatic logic covers(input inh_mask_t query, input inh_mask_t held);
        return (|query) && ((query & ~held) == '0);
    endfunction

endpackage

// File: rtl/shadow_state.sv
module shadow_state
    import shadow_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] icount,
    input  logic             arm,
    input  inh_mask_t        arm_mask,
    input  logic             clr,
    output inh_mask_t        held_mask,
    output logic [CNT_W-1:0] end_cnt,
    output logic             in_win
);

    logic [CNT_W-1:0] gap;
    logic             ss_live;
    logic             take_arm;

    // Wrap-safe "icount <= end_cnt": the signed difference is non-negative.
    assign gap      = end_cnt - icount;
    assign in_win   = ~gap[CNT_W-1];
    assign ss_live  = in_win && held_mask[BIT_SS];
    assign take_arm = arm && !clr && !ss_live;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_mask <= '0;
            end_cnt   <= '0;
        end else if (clr) begin
            held_mask <= '0;
        end else if (take_arm) begin
            held_mask <= widen_arm(arm_mask);
            end_cnt   <= icount + CNT_W'(1);
        end
    end

    p_arm_store_r1: assert property (@(posedge clk) disable iff (rst)
        (arm && !clr && !(held_mask[BIT_SS] && in_win))
        |=> (end_cnt == $past(icount) + CNT_W'(1)) && (held_mask == widen_arm($past(arm_mask))));

    p_ss_widen_r2: assert property (@(posedge clk) disable iff (rst)
        (arm && !clr && !(held_mask[BIT_SS] && in_win) && arm_mask[BIT_SS])
        |=> (held_mask == '1));

    p_no_chain_r3: assert property (@(posedge clk) disable iff (rst)
        (arm && !clr && held_mask[BIT_SS] && in_win)
        |=> ($stable(held_mask) && $stable(end_cnt)));

    p_clear_wins_r6: assert property (@(posedge clk) disable iff (rst)
        clr |=> (held_mask == '0));

endmodule

// File: rtl/shadow_probe.sv
module shadow_probe
    import shadow_pkg::*;
(
    input  logic      in_win,
    input  inh_mask_t held_mask,
    input  inh_mask_t query,
    output logic      hit
);

    assign hit = in_win && covers(query, held_mask);

endmodule

// File: rtl/irq_shadow_tracker.sv
module irq_shadow_tracker
    import shadow_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int NQ    = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [CNT_W-1:0]    icount,
    input  logic                arm,
    input  logic [MASK_W-1:0]   arm_mask,
    input  logic                clr,
    input  logic [NQ*MASK_W-1:0] q_mask,
    output logic [NQ-1:0]       q_hit
);

    inh_mask_t        held_mask;
    logic [CNT_W-1:0] end_cnt;
    logic             in_win;

    shadow_state #(.CNT_W(CNT_W)) u_state (
        .clk      (clk),
        .rst      (rst),
        .icount   (icount),
        .arm      (arm),
        .arm_mask (arm_mask),
        .clr      (clr),
        .held_mask(held_mask),
        .end_cnt  (end_cnt),
        .in_win   (in_win)
    );

    for (genvar i = 0; i < NQ; i++) begin : g_probe
        shadow_probe u_probe (
            .in_win   (in_win),
            .held_mask(held_mask),
            .query    (q_mask[i*MASK_W +: MASK_W]),
            .hit      (q_hit[i])
        );

        p_hit_needs_mask_r4: assert property (@(posedge clk) disable iff (rst)
            q_hit[i] |-> ((q_mask[i*MASK_W +: MASK_W] & ~held_mask) == '0));

        p_empty_query_r10: assert property (@(posedge clk) disable iff (rst)
            (q_mask[i*MASK_W +: MASK_W] == '0) |-> !q_hit[i]);

        p_hit_in_window_r8: assert property (@(posedge clk) disable iff (rst)
            q_hit[i] |-> !((end_cnt - icount) >> (CNT_W-1)));
    end

endmodule

// File: tb/irq_shadow_tracker_test.sv
module irq_shadow_tracker_test;

    localparam int CLK_PERIOD = 10;
    localparam int CW = 32;
    localparam int NQ = 2;

    logic          clk = 0;
    logic          rst;
    logic [CW-1:0] icount;
    logic          arm;
    logic [2:0]    arm_mask;
    logic          clr;
    logic [NQ*3-1:0] q_mask;
    logic [NQ-1:0] q_hit;

    int n_cmp = 0;
    int n_bad = 0;

    irq_shadow_tracker #(.CNT_W(CW), .NQ(NQ)) uut (
        .clk(clk), .rst(rst), .icount(icount), .arm(arm), .arm_mask(arm_mask),
        .clr(clr), .q_mask(q_mask), .q_hit(q_hit)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0b expected %0b at t=%0t", req, act, exp, $time);
        end
    endtask

    // one rising edge, return just after the falling edge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        arm = 0; clr = 0;
    endtask

    task automatic q0(input string req, input logic [CW-1:0] cnt, input logic [2:0] m, input logic exp);
        icount = cnt; q_mask = {3'b000, m};
        #1;
        check(req, q_hit[0], exp);
    endtask

    task automatic do_arm(input logic [CW-1:0] cnt, input logic [2:0] m);
        icount = cnt; arm = 1; arm_mask = m;
        step();
    endtask

    task automatic t_reset();
        rst = 1; arm = 0; clr = 0; arm_mask = 0; icount = 0; q_mask = 0;
        step(); step();
        rst = 0;
        q0("R7", 0, 3'b001, 0);
        q0("R7", 0, 3'b111, 0);
    endtask

    task automatic t_arm_basic();
        do_arm(100, 3'b001);
        q0("R1", 100, 3'b001, 1);
        q0("R1", 101, 3'b001, 1);
        q0("R8", 102, 3'b001, 0);
        q0("R4", 101, 3'b010, 0);
        q0("R4", 101, 3'b011, 0);
    endtask

    task automatic t_ss_expand();
        do_arm(200, 3'b100);
        q0("R2", 200, 3'b111, 1);
        q0("R2", 201, 3'b001, 1);
        q0("R2", 201, 3'b010, 1);
    endtask

    task automatic t_no_chain();
        do_arm(201, 3'b010);
        q0("R3", 201, 3'b111, 1);
        q0("R3", 202, 3'b010, 0);
    endtask

    task automatic t_after_expire();
        do_arm(202, 3'b010);
        q0("R3", 203, 3'b010, 1);
        q0("R3", 203, 3'b001, 0);
        do_arm(203, 3'b001);
        q0("R1", 204, 3'b001, 1);
        q0("R1", 204, 3'b010, 0);
    endtask

    task automatic t_clear();
        icount = 204; clr = 1;
        step();
        q0("R6", 204, 3'b001, 0);
        icount = 300; arm = 1; arm_mask = 3'b001; clr = 1;
        step();
        q0("R6", 300, 3'b001, 0);
        q0("R6", 301, 3'b001, 0);
    endtask

    task automatic t_wrap();
        do_arm(32'hFFFF_FFFF, 3'b001);
        q0("R5", 32'hFFFF_FFFF, 3'b001, 1);
        q0("R5", 0, 3'b001, 1);
        q0("R5", 1, 3'b001, 0);
    endtask

    task automatic t_same_cycle();
        icount = 500; arm = 1; arm_mask = 3'b010; q_mask = {3'b000, 3'b010};
        #1;
        check("R4", q_hit[0], 0);
        step();
        q0("R4", 500, 3'b010, 1);
        q0("R10", 500, 3'b000, 0);
    endtask

    task automatic t_multi();
        icount = 501; q_mask = {3'b010, 3'b001};
        #1;
        check("R9", q_hit[0], 0);
        check("R9", q_hit[1], 1);
        q_mask = {3'b000, 3'b010};
        #1;
        check("R10", q_hit[1], 0);
        check("R9", q_hit[0], 1);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_arm_basic();
        t_ss_expand();
        t_no_chain();
        t_after_expire();
        t_clear();
        t_wrap();
        t_same_cycle();
        t_multi();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule